// File: doc/BRIEF.md
# Slot Power and Reset Sequencer

This block sequences power and reset for a single downstream hot-plug slot. A level-sensitive control bit from the register side asks for the slot to be powered (bit low) or unpowered (bit high). The block drives a power-enable output to the slot supply and an active-low reset output to the slot. It orders the two outputs so that the slot never sees reset released while its power is off.

Two timing modes exist. In enable-timed mode, the reset release is counted from the cycle in which power-enable asserts. In good-timed mode, the block first waits for the active-low power-good input from the slot supply. That input is brought through a two-flop synchronizer. The reset release is counted from the cycle in which the synchronized level is seen. In both modes, powering down asserts reset at once and drops power-enable after a second programmable delay. Both delays are counted in cycles of the single clock. A busy output marks the transitional phases.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset, slot_pwr_en is 0, slot_rst_n is 0 and seq_busy is 0.
- R2: pwr_off_req = 1 requests power off and pwr_off_req = 0 requests power on. Whenever slot_pwr_en is 0, slot_rst_n is 0.
- R3: In enable-timed mode (mode_good = 0), slot_pwr_en rises on the first clock edge that samples pwr_off_req = 0. slot_rst_n rises on_dly + 1 edges later, so a value of 0 releases reset on the next edge.
- R4: In good-timed mode (mode_good = 1), slot_pwr_en rises on the request edge, and slot_rst_n stays 0 while pwr_good_n is high. Let the first edge that samples pwr_good_n = 0 be edge e. Then slot_rst_n rises on edge e + on_dly + 3: two synchronizer stages, one cycle of detection, and on_dly + 1 cycles of counting.
- R5: In good-timed mode, the power-good input is taken as a level. A supply that is already good lets the sequence proceed without any new edge.
- R6: A power-off request asserts slot_rst_n low on the first edge that samples pwr_off_req = 1. slot_pwr_en falls off_dly + 1 edges after that.
- R7: A power-off request during power-up aborts the power-up. slot_rst_n is never released, and the power-down delay runs from the abort edge.
- R8: Once the power-down delay has started, pwr_off_req is ignored until slot_pwr_en has fallen.
- R9: seq_busy is 1 exactly while slot_pwr_en is 1 and slot_rst_n is 0, which are the transitional phases.
- R10: Once the power-up sequence has completed, slot_rst_n stays 1 for as long as pwr_off_req stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_off_req | input | 1 | Power control, 1 = off, 0 = on |
| mode_good | input | 1 | 0 = enable-timed, 1 = good-timed |
| on_dly | input | DLY_W | Power-to-reset-release delay in cycles |
| off_dly | input | DLY_W | Reset-to-power-off delay in cycles |
| pwr_good_n | input | 1 | Asynchronous active-low power-good from the slot supply |
| slot_pwr_en | output | 1 | Slot power enable |
| slot_rst_n | output | 1 | Slot reset, active low |
| seq_busy | output | 1 | High during a transitional phase |

## Verification
Several orderings are checked on every cycle. Reset is never released without power. Power is never removed unless reset was already asserted. Reset stays released while power is still requested. The power-down phase cannot be cut short, and the delay counter takes the delay value it was loaded with. Exact cycle counts are shown only by the bench scenarios: the delay from power-enable to reset release for zero and non-zero delays, the three-cycle latency through the synchronizer, progress with a supply that is already good, the abort during power-up, and a request that is ignored during power-down.

// File: rtl/slot_pwr_seq_pkg.sv
package slot_pwr_seq_pkg;
  typedef enum logic [2:0] {
    SEQ_OFF       = 3'd0,
    SEQ_WAIT_GOOD = 3'd1,
    SEQ_PWR_DLY   = 3'd2,
    SEQ_ON        = 3'd3,
    SEQ_RST_DLY   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/slot_pg_sync.sv
module slot_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sr_d = din;
    end else begin : g_many
      assign sr_d = {sr_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/slot_dly_cnt.sv
module slot_dly_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load | (dec & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/slot_seq_fsm.sv
module slot_seq_fsm
  import slot_pwr_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic off_req,
  input  logic mode_good,
  input  logic good_s,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_sel_off,
  output logic cnt_dec,
  output logic pwr_en,
  output logic rst_out_n,
  output logic busy
);
  seq_state_t st_q;
  seq_state_t st_d;

  always_comb begin
    st_d        = st_q;
    cnt_load    = 1'b0;
    cnt_sel_off = 1'b0;
    cnt_dec     = 1'b0;
    case (st_q)
      SEQ_OFF: begin
        if (!off_req) begin
          cnt_load = 1'b1;
          st_d     = mode_good ? SEQ_WAIT_GOOD : SEQ_PWR_DLY;
        end
      end
      SEQ_WAIT_GOOD: begin
        if (off_req) begin
          cnt_load    = 1'b1;
          cnt_sel_off = 1'b1;
          st_d        = SEQ_RST_DLY;
        end else if (good_s) begin
          cnt_load = 1'b1;
          st_d     = SEQ_PWR_DLY;
        end
      end
      SEQ_PWR_DLY: begin
        if (off_req) begin
          cnt_load    = 1'b1;
          cnt_sel_off = 1'b1;
          st_d        = SEQ_RST_DLY;
        end else if (cnt_zero) begin
          st_d = SEQ_ON;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      SEQ_ON: begin
        if (off_req) begin
          cnt_load    = 1'b1;
          cnt_sel_off = 1'b1;
          st_d        = SEQ_RST_DLY;
        end
      end
      SEQ_RST_DLY: begin
        if (cnt_zero) st_d = SEQ_OFF;
        else          cnt_dec = 1'b1;
      end
      default: st_d = SEQ_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_OFF;
    else        st_q <= st_d;
  end

  assign pwr_en    = (st_q != SEQ_OFF);
  assign rst_out_n = (st_q == SEQ_ON);
  assign busy      = (st_q == SEQ_WAIT_GOOD) || (st_q == SEQ_PWR_DLY) ||
                     (st_q == SEQ_RST_DLY);

  // R2
  rst_without_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !rst_out_n);
  // R3
  release_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(pwr_en));
  // R6
  pwr_drop_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(!rst_out_n));
  // R4
  hold_until_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_WAIT_GOOD && !good_s && !off_req) |=> (st_q == SEQ_WAIT_GOOD));
  // R8
  rst_dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_RST_DLY && !cnt_zero) |=> (pwr_en && !rst_out_n));
  // R10
  on_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out_n && !off_req) |=> rst_out_n);
  // R9
  busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pwr_en && !rst_out_n));
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq #(
  parameter int DLY_W     = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_off_req,
  input  logic             mode_good,
  input  logic [DLY_W-1:0] on_dly,
  input  logic [DLY_W-1:0] off_dly,
  input  logic             pwr_good_n,
  output logic             slot_pwr_en,
  output logic             slot_rst_n,
  output logic             seq_busy
);
  logic             good_s;
  logic             cnt_load;
  logic             cnt_sel_off;
  logic             cnt_dec;
  logic             cnt_zero;
  logic [DLY_W-1:0] cnt_val;

  slot_pg_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (~pwr_good_n),
    .dout (good_s)
  );

  assign cnt_val = cnt_sel_off ? off_dly : on_dly;

  slot_dly_cnt #(.DLY_W(DLY_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cnt_val),
    .dec     (cnt_dec),
    .zero    (cnt_zero)
  );

  slot_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_req    (pwr_off_req),
    .mode_good  (mode_good),
    .good_s     (good_s),
    .cnt_zero   (cnt_zero),
    .cnt_load   (cnt_load),
    .cnt_sel_off(cnt_sel_off),
    .cnt_dec    (cnt_dec),
    .pwr_en     (slot_pwr_en),
    .rst_out_n  (slot_rst_n),
    .busy       (seq_busy)
  );
endmodule

// File: tb/slot_pwr_seq_test.sv
module slot_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_off_req = 1'b1;
  logic          mode_good = 1'b0;
  logic [DW-1:0] on_dly = '0;
  logic [DW-1:0] off_dly = '0;
  logic          pwr_good_n = 1'b1;
  logic          slot_pwr_en;
  logic          slot_rst_n;
  logic          seq_busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pwr_seq #(.DLY_W(DW), .SYNC_STGS(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_off_req(pwr_off_req), .mode_good(mode_good),
    .on_dly(on_dly), .off_dly(off_dly), .pwr_good_n(pwr_good_n),
    .slot_pwr_en(slot_pwr_en), .slot_rst_n(slot_rst_n), .seq_busy(seq_busy)
  );

  // reference model: 0 off, 1 wait good, 2 counting up, 3 on, 4 counting down
  int m_phase = 0;
  int m_left = 0;
  bit pg_pipe[$] = '{1'b0, 1'b0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_left = 0;
      pg_pipe = '{1'b0, 1'b0};
    end else begin
      bit seen_good;
      seen_good = pg_pipe.pop_front();
      pg_pipe.push_back(~pwr_good_n);
      case (m_phase)
        0: if (!pwr_off_req) begin m_left = on_dly; m_phase = mode_good ? 1 : 2; end
        1: if (pwr_off_req) begin m_left = off_dly; m_phase = 4; end
           else if (seen_good) begin m_left = on_dly; m_phase = 2; end
        2: if (pwr_off_req) begin m_left = off_dly; m_phase = 4; end
           else if (m_left == 0) m_phase = 3;
           else m_left--;
        3: if (pwr_off_req) begin m_left = off_dly; m_phase = 4; end
        4: if (m_left == 0) m_phase = 0;
           else m_left--;
        default: m_phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(slot_pwr_en == (m_phase != 0), "R2 R3 R6 pwr_en vs model", slot_pwr_en, m_phase != 0);
      check(slot_rst_n == (m_phase == 3), "R4 R7 R10 rst_n vs model", slot_rst_n, m_phase == 3);
      check(seq_busy == (m_phase == 1 || m_phase == 2 || m_phase == 4),
            "R9 busy vs model", seq_busy, m_phase == 1 || m_phase == 2 || m_phase == 4);
    end
  end

  task automatic cycles_until_rst_hi(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!slot_rst_n && n < 300);
  endtask

  task automatic cycles_until_pwr_lo(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (slot_pwr_en && n < 300);
  endtask

  task automatic power_off(input int d);
    int n;
    off_dly = d[DW-1:0];
    pwr_off_req = 1'b1;
    cycles_until_pwr_lo(n);
  endtask

  initial begin
    fork
      begin : scen
        int n;
        repeat (3) @(negedge clk);
        // R1
        check(!slot_pwr_en && !slot_rst_n && !seq_busy, "R1 reset state",
              {slot_pwr_en, slot_rst_n, seq_busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2: off request held keeps everything low
        check(!slot_pwr_en && !slot_rst_n, "R2 idle while off", slot_pwr_en, 0);

        // R3: enable-timed, delay 3
        mode_good = 1'b0; on_dly = 8'd3;
        pwr_off_req = 1'b0;
        @(negedge clk);
        check(slot_pwr_en && !slot_rst_n, "R3 pwr_en first", slot_rst_n, 0);
        cycles_until_rst_hi(n);
        check(n == 4, "R3 release delay 3", n + 1, 5);
        // R10
        repeat (20) @(negedge clk);
        check(slot_rst_n == 1'b1, "R10 held released", slot_rst_n, 1);

        // R6: off with delay 2
        off_dly = 8'd2;
        pwr_off_req = 1'b1;
        @(negedge clk);
        check(!slot_rst_n && slot_pwr_en, "R6 reset before power", slot_pwr_en, 1);
        cycles_until_pwr_lo(n);
        check(n == 3, "R6 power drop delay 2", n + 1, 4);
        repeat (2) @(negedge clk);

        // R3: delay 0 releases on the next edge
        on_dly = 8'd0;
        pwr_off_req = 1'b0;
        cycles_until_rst_hi(n);
        check(n == 2, "R3 release delay 0", n, 2);
        power_off(0);
        repeat (2) @(negedge clk);

        // R4: good-timed, supply not yet good
        mode_good = 1'b1; on_dly = 8'd2; pwr_good_n = 1'b1;
        pwr_off_req = 1'b0;
        repeat (10) @(negedge clk);
        check(slot_pwr_en && !slot_rst_n && seq_busy, "R4 waits for good", slot_rst_n, 0);
        pwr_good_n = 1'b0;
        cycles_until_rst_hi(n);
        check(n == 6, "R4 release after good", n, 6);
        power_off(1);
        repeat (2) @(negedge clk);

        // R5: supply already good
        on_dly = 8'd1;
        pwr_off_req = 1'b0;
        cycles_until_rst_hi(n);
        check(n == 4, "R5 already good", n, 4);
        power_off(3);
        pwr_good_n = 1'b1;
        repeat (3) @(negedge clk);

        // R7: abort during power-up
        mode_good = 1'b0; on_dly = 8'd10; off_dly = 8'd2;
        pwr_off_req = 1'b0;
        repeat (3) @(negedge clk);
        pwr_off_req = 1'b1;
        n = 0;
        for (int i = 0; i < 15; i++) begin
          @(negedge clk);
          if (slot_rst_n) n++;
        end
        check(n == 0 && !slot_pwr_en, "R7 abort never releases", n, 0);

        // R8: request ignored during power-down
        on_dly = 8'd0;
        pwr_off_req = 1'b0;
        cycles_until_rst_hi(n);
        off_dly = 8'd5;
        pwr_off_req = 1'b1;
        repeat (2) @(negedge clk);
        pwr_off_req = 1'b0;
        cycles_until_pwr_lo(n);
        check(n == 5, "R8 power-down completes", n + 2, 7);
        @(negedge clk);
        check(slot_pwr_en == 1'b1, "R8 re-power afterwards", slot_pwr_en, 1);
        power_off(0);
        repeat (5) @(negedge clk);
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule